// File: doc/BRIEF.md
# PCI Bus Arbiter with Idle Parking

This block decides which of eight masters may drive a conventional PCI bus. Index 0 is the host-side master. Indices 1 to 7 are external masters. Every master has an active-low request input and receives an active-low grant output, and at most one grant is low at a time. The next owner is picked round-robin among the enabled requests. The search begins just past the index that was granted most recently.

The arbiter treats the bus as idle whenever FRAME# and IRDY# are both high, and it counts consecutive idle clocks. Grants only move while the bus is idle. A change of owner always passes through one clock in which no grant is low. When no enabled request is pending and the idle count has reached the programmed parking count, the bus is parked. In one parking mode it parks on the host master; in the other it parks on the last granted master. The request-enable mask, the parking mode and the parking count are static control inputs. The parking count is normally programmed to 7.

Top module: `pci_park_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, all `gnt_n` bits go high after that edge, the last-owner record becomes index 0 and the idle count becomes 0.
- R2: In every cycle at most one bit of `gnt_n` is low.
- R3: The host request (`req_n[0]`) is always honoured, whatever `req_en[0]` holds. An external request `i` whose `req_en[i]` is 0 is ignored, so it never wins a grant.
- R4: Among enabled, asserted requests, the winner is the first index found searching upward (wrapping from 7 to 0) from the index after the most recently granted one.
- R5: If `frame_n` or `irdy_n` is low in a cycle, `gnt_n` is unchanged after the following edge.
- R6: When the granted index changes, `gnt_n` is all ones for exactly one clock between the old owner and the new one.
- R7: The idle count is the number of consecutive earlier cycles with both `frame_n` and `irdy_n` high. It drops to 0 after any cycle in which either signal is low, and it saturates at its maximum value.
- R8: With no enabled request pending, the parking grant is issued at the edge ending the idle cycle in which the idle count equals `park_cnt`. This is the (`park_cnt`+1)-th consecutive idle cycle. A count of 0 therefore parks at the end of the first idle cycle.
- R9: `park_mode` = 0 parks on index 0; `park_mode` = 1 parks on the most recently granted index.
- R10: In an idle cycle with no enabled request and the parking count not reached, all `gnt_n` bits are high after the edge.
- R11: In an idle cycle with no grant active and at least one enabled request, a grant goes low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | N_MASTERS | Active-low requests; bit 0 is the host master |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| req_en | input | N_MASTERS | Request-enable mask; bit 0 is treated as 1 |
| park_mode | input | 1 | 0: park on host, 1: park on last owner |
| park_cnt | input | CNT_W | Idle clocks before parking |
| gnt_n | output | N_MASTERS | Active-low one-hot grants |

## Verification
The bench builds the arbiter with eight masters and a 4-bit idle counter. The narrow counter makes its saturation at 15 reachable in a short run. A parking count of 15 then shows that the saturated counter keeps the parked grant in place and does not wrap and drop it. The default eight-master width allows the round-robin search to wrap from index 7 back to index 1. It also lets the bench mask index 6 and clear the host enable bit, showing that the host request still wins.

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter #(
  parameter int N_MASTERS = 8,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  input  logic [N_MASTERS-1:0] req_en,
  input  logic                 park_mode,
  input  logic [CNT_W-1:0]     park_cnt,
  output logic [N_MASTERS-1:0] gnt_n
);
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS-1:0] gnt_q, eff, tgt_oh;
  logic [IW-1:0]        last_q, win, tgt;
  logic [CNT_W-1:0]     idle_cnt;
  logic                 idle, park_hit, tgt_vld, found;

  assign idle     = frame_n & irdy_n;
  assign eff      = ~req_n & (req_en | N_MASTERS'(1));
  assign park_hit = idle && (idle_cnt >= park_cnt);
  assign gnt_n    = ~gnt_q;

  always_comb begin
    win   = last_q;
    found = 1'b0;
    for (int k = 1; k <= N_MASTERS; k++) begin
      if (!found && eff[(int'(last_q) + k) % N_MASTERS]) begin
        found = 1'b1;
        win   = IW'((int'(last_q) + k) % N_MASTERS);
      end
    end
  end

  always_comb begin
    tgt_vld = 1'b0;
    tgt     = last_q;
    if (|eff) begin
      tgt_vld = 1'b1;
      tgt     = win;
    end else if (park_hit) begin
      tgt_vld = 1'b1;
      tgt     = park_mode ? last_q : '0;
    end
  end

  assign tgt_oh = N_MASTERS'(1) << tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q    <= '0;
      last_q   <= '0;
      idle_cnt <= '0;
    end else if (!idle) begin
      idle_cnt <= '0;
    end else begin
      if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
      if (!tgt_vld) begin
        gnt_q <= '0;
      end else if (gnt_q == '0) begin
        gnt_q  <= tgt_oh;
        last_q <= tgt;
      end else if (gnt_q != tgt_oh) begin
        gnt_q <= '0;
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> gnt_n == '1)
    else $error("R1 grants not released by reset");

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~gnt_n))
    else $error("R2 more than one grant");

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n || !irdy_n) |=> $stable(gnt_n))
    else $error("R5 grant moved while bus busy");

  p_dead_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != '1) |=> (gnt_n == '1 || $stable(gnt_n)))
    else $error("R6 owner changed without a dead cycle");

  p_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && eff == '0 && !park_hit) |=> gnt_n == '1)
    else $error("R10 grant held with no request");

  p_grant_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && gnt_q == '0 && eff != '0) |=> gnt_n != '1)
    else $error("R11 pending request not granted");
endmodule

// File: tb/pci_park_arbiter_test.sv
module pci_park_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_n = 8'hFF;
  logic       frame_n = 1'b1, irdy_n = 1'b1;
  logic [7:0] req_en = 8'hFE;
  logic       park_mode = 1'b0;
  logic [3:0] park_cnt = 4'd3;
  logic [7:0] gnt_n;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  pci_park_arbiter #(.N_MASTERS(8), .CNT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .req_en(req_en), .park_mode(park_mode), .park_cnt(park_cnt), .gnt_n(gnt_n));

  always #2 clk = ~clk;

  task automatic step(input logic [7:0] rq, input logic fr, input logic ir,
                      input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_n = ~rq; frame_n = fr; irdy_n = ir;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (gnt_n !== e) begin
          errors++;
          $display("FAIL %s: gnt_n=%h expected %h", t, gnt_n, e);
        end
        checks++;
        if ($countones(~gnt_n) > 1) begin
          errors++;
          $display("FAIL R2: gnt_n=%h expected at most one low bit", gnt_n);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(8'h00, 1, 1, 8'hFF, "R1 reset");
    step(8'h08, 1, 1, 8'hFF, "R1 reset ignores request");
    rst_n = 1'b1;
    // parking on host after 3 idle counts
    step(8'h00, 1, 1, 8'hFF, "R10 idle 1");
    step(8'h00, 1, 1, 8'hFF, "R10 idle 2");
    step(8'h00, 1, 1, 8'hFF, "R10 idle 3");
    step(8'h00, 1, 1, 8'hFE, "R8 park at count 3");
    step(8'h00, 1, 1, 8'hFE, "R8 park held");
    // hand-off to master 3, busy hold
    step(8'h08, 1, 1, 8'hFF, "R6 dead cycle to 3");
    step(8'h08, 1, 1, 8'hF7, "R11 grant 3");
    step(8'h08, 0, 1, 8'hF7, "R5 busy hold");
    step(8'h00, 0, 1, 8'hF7, "R5 busy hold no req");
    step(8'h20, 0, 1, 8'hF7, "R5 busy hold new req");
    step(8'h20, 1, 1, 8'hFF, "R6 dead cycle to 5");
    step(8'h20, 1, 1, 8'hDF, "R4 grant 5");
    // mask master 6
    req_en = 8'hBE;
    step(8'h40, 1, 1, 8'hFF, "R3 masked request ignored");
    step(8'h40, 1, 1, 8'hFE, "R9 mode 0 parks host");
    // host request with its enable bit cleared
    park_cnt = 4'd15;
    step(8'h02, 1, 1, 8'hFF, "R6 dead cycle to 1");
    step(8'h02, 1, 1, 8'hFD, "R11 grant 1");
    step(8'h41, 1, 1, 8'hFF, "R3 host wins over masked 6");
    step(8'h41, 1, 1, 8'hFE, "R3 host granted");
    // round robin 1,2,7 wrap to 1
    step(8'h86, 1, 1, 8'hFF, "R4 rr dead");
    step(8'h86, 1, 1, 8'hFD, "R4 rr 1");
    step(8'h86, 1, 1, 8'hFF, "R4 rr dead");
    step(8'h86, 1, 1, 8'hFB, "R4 rr 2");
    step(8'h86, 1, 1, 8'hFF, "R4 rr dead");
    step(8'h86, 1, 1, 8'h7F, "R4 rr 7");
    step(8'h86, 1, 1, 8'hFF, "R4 rr dead");
    step(8'h86, 1, 1, 8'hFD, "R4 rr wrap to 1");
    // mode 1 parking at saturated count 15
    park_mode = 1'b1;
    step(8'h00, 0, 1, 8'hFD, "R5 busy hold");
    for (int i = 0; i < 15; i++) step(8'h00, 1, 1, 8'hFF, "R10 waiting for 15");
    step(8'h00, 1, 1, 8'hFD, "R9 mode 1 parks last owner");
    step(8'h00, 1, 1, 8'hFD, "R7 saturated count keeps park");
    // IRDY# low restarts the count
    park_cnt = 4'd2;
    park_mode = 1'b0;
    step(8'h00, 1, 0, 8'hFD, "R5 irdy busy hold");
    step(8'h00, 1, 1, 8'hFF, "R10 idle 1");
    step(8'h00, 1, 1, 8'hFF, "R10 idle 2");
    step(8'h00, 1, 0, 8'hFF, "R7 irdy low");
    step(8'h00, 1, 1, 8'hFF, "R7 count restarted");
    step(8'h00, 1, 1, 8'hFF, "R7 count restarted 2");
    step(8'h00, 1, 1, 8'hFE, "R7 park after restart");
    // count 0 parks on first idle clock
    park_cnt = 4'd0;
    park_mode = 1'b1;
    step(8'h10, 1, 1, 8'hFF, "R6 dead cycle to 4");
    step(8'h10, 1, 1, 8'hEF, "R11 grant 4");
    step(8'h00, 0, 1, 8'hEF, "R5 busy hold");
    step(8'h00, 1, 1, 8'hEF, "R8 count 0 parks at once");
    step(8'h00, 1, 1, 8'hEF, "R9 mode 1 held on 4");
    @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule